// File: doc/BRIEF.md
# UART Bit-Rate and Break Timer

This block produces the timing strobes a UART transmitter and receiver run on. A reference clock passes through a 4-bit predivider, then through a programmable sample divider, and finally through a fixed count of 13 samples per bit. The predivider is meant to bring the reference down to roughly 12 MHz before the bit-timing stage. The block emits a one-cycle sample strobe and a one-cycle bit strobe. A bit period is therefore 13 × (predivider + 1) × (divisor + 1) reference cycles.

Software writes a new rate word through a plain write strobe. The block holds the word as pending and raises a busy flag. The word takes effect only while the transmitter reports idle or at the end of a character. Software is expected to wait for busy to clear before writing again. The block also times the transmit break. A break-count register sets the length in bit periods. A start pulse raises a break-active output, which forces the serial line low. When the count runs out, the block raises a one-cycle break-done pulse for the interrupt logic, and break-active falls.

All pins are plain control and status signals. No stream interface is involved, so there is no back-pressure.

Top module: `baud_break_timer`

## Requirements
- R1: In the rate word, bits 19:16 give the predivider minus one and bits 9:0 give the sample divisor minus one. All other bits of the word have no effect on the strobe timing.
- R2: Once a rate word is applied on a clock edge, `sample_tick` is high for exactly one cycle every (pre+1)×(div+1) cycles. The first pulse comes that many cycles after the applying edge.
- R3: `bit_tick` is high for one cycle on every 13th sample strobe, and always in the same cycle as a `sample_tick`. The first bit strobe comes 13×(pre+1)×(div+1) cycles after the applying edge.
- R4: The cycle after a `div_wr` pulse, `div_busy` is 1.
- R5: While `div_busy` is 1 and neither `tx_idle` nor `tx_char_end` is 1, the pending word is not applied and busy stays high. The first edge at which either input is 1 (with no write) applies the word, clears busy and restarts the strobe counters.
- R6: A `brk_start` pulse with a nonzero break count N raises `brk_active` on the next cycle. `brk_active` stays high for exactly N bit strobes. `brk_done` pulses for one cycle, together with the Nth bit strobe, as `brk_active` falls.
- R7: A `brk_start` pulse with a break count of 0 produces a `brk_done` pulse on the next cycle and never raises `brk_active`.
- R8: A `brk_start` pulse while `brk_active` is 1 is ignored. A write to the break count while active does not change the running break.
- R9: Reset clears both rate fields to zero, so each sample strobe is one cycle apart. Reset also clears the strobes, busy, break-active and break-done.
- R10: A `div_wr` while busy replaces the pending word. Only the last word written is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the rate word |
| div_wdata | input | 32 | Rate word: predivider-1 at 19:16, divisor-1 at 9:0 |
| brk_cnt_wr | input | 1 | Write strobe for the break count |
| brk_cnt_wdata | input | BRK_W | Break length in bit periods |
| brk_start | input | 1 | Break request pulse |
| tx_idle | input | 1 | Transmitter idle; a pending rate may be applied |
| tx_char_end | input | 1 | Character boundary pulse; a pending rate may be applied |
| sample_tick | output | 1 | One-cycle sample strobe |
| bit_tick | output | 1 | One-cycle bit strobe |
| div_busy | output | 1 | A written rate word is still pending |
| brk_active | output | 1 | Break in progress; the transmit line must be held low |
| brk_done | output | 1 | One-cycle pulse when a break ends |

## Verification
The hardest situation to reach is a rate word that stays pending while the old rate keeps running, and is then replaced by a second write before any boundary arrives. The stimulus holds `tx_idle` low for a random number of cycles and writes twice. It then releases the word with a lone `tx_char_end` pulse and times the strobes against the second word's fields. A break is also re-requested, and its count rewritten, in the middle of its run. The stimulus waits for the first observed bit strobe inside the break, so that the request lands while the break is certainly active.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PRE_W   = 4;
  localparam int unsigned PRE_LSB = 16;
  localparam int unsigned DIV_W   = 10;
  localparam int unsigned DIV_LSB = 0;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } rate_cfg_t;
endpackage

// File: rtl/bbt_rate_sel.sv
module bbt_rate_sel
  import bbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              tx_idle,
  input  logic              tx_char_end,
  output rate_cfg_t         cfg,
  output logic              busy,
  output logic              apply
);
  rate_cfg_t pend;
  logic      unused_bits;

  assign unused_bits = ^{wdata[WORD_W-1:PRE_LSB+PRE_W], wdata[PRE_LSB-1:DIV_LSB+DIV_W]};
  // A write always wins; the pending word moves over only on a quiet boundary.
  assign apply = !wr && busy && (tx_idle || tx_char_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      cfg  <= '0;
      busy <= 1'b0;
    end else if (wr) begin
      pend.pre <= wdata[PRE_LSB +: PRE_W];
      pend.div <= wdata[DIV_LSB +: DIV_W];
      busy     <= 1'b1;
    end else if (apply) begin
      cfg  <= pend;
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bbt_strobe_gen.sv
module bbt_strobe_gen
  import bbt_pkg::*;
#(
  parameter int unsigned OSR = 13
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cfg_t cfg,
  input  logic      restart,
  output logic      sample_tick,
  output logic      bit_tick,
  output logic      bit_step
);
  localparam int unsigned BIT_CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(OSR - 1);

  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]  smp_cnt;
  logic [BIT_CW-1:0] bit_cnt;
  logic pre_wrap, smp_wrap, bit_wrap;

  always_comb begin
    pre_wrap = (pre_cnt == cfg.pre);
    smp_wrap = pre_wrap && (smp_cnt == cfg.div);
    bit_wrap = smp_wrap && (bit_cnt == BIT_LAST);
  end

  // The break timer sees a bit boundary only if the counters are not restarting.
  assign bit_step = bit_wrap && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_cnt     <= '0;
      smp_cnt     <= '0;
      bit_cnt     <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) smp_cnt <= smp_wrap ? '0 : smp_cnt + 1'b1;
      if (smp_wrap) bit_cnt <= bit_wrap ? '0 : bit_cnt + 1'b1;
      sample_tick <= smp_wrap;
      bit_tick    <= bit_wrap;
    end
  end
endmodule

// File: rtl/bbt_break_tmr.sv
module bbt_break_tmr #(
  parameter int unsigned BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [BRK_W-1:0] cnt_wdata,
  input  logic             start,
  input  logic             step,
  output logic             active,
  output logic             done
);
  logic [BRK_W-1:0] cnt_q;
  logic [BRK_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      remain <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cnt_wr) cnt_q <= cnt_wdata;
      if (!active && start) begin
        if (cnt_q == '0) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1;
          remain <= cnt_q;
        end
      end else if (active && step) begin
        if (remain == BRK_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_break_timer.sv
module baud_break_timer
  import bbt_pkg::*;
#(
  parameter int unsigned OSR   = 13,
  parameter int unsigned BRK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic [WORD_W-1:0] div_wdata,
  input  logic              brk_cnt_wr,
  input  logic [BRK_W-1:0]  brk_cnt_wdata,
  input  logic              brk_start,
  input  logic              tx_idle,
  input  logic              tx_char_end,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic              div_busy,
  output logic              brk_active,
  output logic              brk_done
);
  rate_cfg_t cfg;
  logic      apply;
  logic      bit_step;

  bbt_rate_sel u_rate_sel (
    .clk(clk), .rst_n(rst_n), .wr(div_wr), .wdata(div_wdata),
    .tx_idle(tx_idle), .tx_char_end(tx_char_end),
    .cfg(cfg), .busy(div_busy), .apply(apply)
  );

  bbt_strobe_gen #(.OSR(OSR)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .restart(apply),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .bit_step(bit_step)
  );

  bbt_break_tmr #(.BRK_W(BRK_W)) u_break (
    .clk(clk), .rst_n(rst_n), .cnt_wr(brk_cnt_wr), .cnt_wdata(brk_cnt_wdata),
    .start(brk_start), .step(bit_step), .active(brk_active), .done(brk_done)
  );
endmodule

// File: rtl/baud_break_timer_sva.sv
module baud_break_timer_sva (
  input logic clk,
  input logic rst_n,
  input logic div_wr,
  input logic tx_idle,
  input logic tx_char_end,
  input logic sample_tick,
  input logic bit_tick,
  input logic div_busy,
  input logic brk_active,
  input logic brk_done
);
  p_bit_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> div_busy);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !tx_idle && !tx_char_end) |=> div_busy);

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && (tx_idle || tx_char_end) && !div_wr) |=> !div_busy);

  p_end_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> brk_done);

  p_done_not_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> !brk_active);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);
endmodule

bind baud_break_timer baud_break_timer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .tx_idle(tx_idle),
  .tx_char_end(tx_char_end), .sample_tick(sample_tick), .bit_tick(bit_tick),
  .div_busy(div_busy), .brk_active(brk_active), .brk_done(brk_done)
);

// File: tb/baud_break_timer_tb_top.sv
`timescale 1ns/1ps
module baud_break_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [31:0] div_wdata = '0;
  logic        brk_cnt_wr = 1'b0;
  logic [15:0] brk_cnt_wdata = '0;
  logic        brk_start = 1'b0;
  logic        tx_idle = 1'b1;
  logic        tx_char_end = 1'b0;
  logic        sample_tick, bit_tick, div_busy, brk_active, brk_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  baud_break_timer dut_i (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .brk_cnt_wr(brk_cnt_wr), .brk_cnt_wdata(brk_cnt_wdata), .brk_start(brk_start),
    .tx_idle(tx_idle), .tx_char_end(tx_char_end), .sample_tick(sample_tick),
    .bit_tick(bit_tick), .div_busy(div_busy), .brk_active(brk_active), .brk_done(brk_done)
  );

  function automatic int exp_smp(input int p, input int d);
    return (p + 1) * (d + 1);
  endfunction

  function automatic int exp_bit(input int p, input int d);
    return 13 * exp_smp(p, d);
  endfunction

  function automatic logic [31:0] make_word(input int p, input int d, input logic [31:0] junk);
    return (junk & ~32'h000F_03FF) | (32'(p) << 16) | 32'(d);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Called at the negedge right after the applying edge (cycle 0).
  task automatic measure(input int p, input int d, input bit full, input string req);
    int n = 0;
    int s = 0;
    do begin @(negedge clk); n++; end while (!sample_tick && n < 20000);
    chk({req, " first sample strobe delay"}, n, exp_smp(p, d));
    if (full) begin
      while (!bit_tick && n < 20000) begin @(negedge clk); n++; end
      chk("R3 first bit strobe delay", n, exp_bit(p, d));
      chk("R3 bit strobe coincides with sample strobe", int'(sample_tick), 1);
      n = 0;
      do begin
        @(negedge clk); n++;
        if (sample_tick) s++;
      end while (!bit_tick && n < 20000);
      chk("R3 bit strobe period", n, exp_bit(p, d));
      chk("R3 sample strobes per bit", s, 13);
    end
  endtask

  // Returns at cycle 0 after the new word is applied.
  task automatic set_div(input logic [31:0] word, input bit use_idle, input int hold);
    int held = 0;
    @(negedge clk);
    div_wr = 1'b1; div_wdata = word; tx_idle = use_idle;
    @(negedge clk);
    div_wr = 1'b0;
    chk("R4 busy after write", int'(div_busy), 1);
    if (!use_idle) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        if (div_busy) held++;
      end
      chk("R5 busy held without boundary", held, hold);
      tx_char_end = 1'b1;
      @(negedge clk);
      tx_char_end = 1'b0;
    end else begin
      @(negedge clk);
    end
    chk("R5 busy cleared at boundary", int'(div_busy), 0);
    tx_idle = 1'b1;
  endtask

  task automatic run_break(input int n, input bit retrig);
    int ticks = 0;
    int cyc = 0;
    bit seen = 1'b0;
    bit trig = 1'b0;
    @(negedge clk);
    brk_cnt_wr = 1'b1; brk_cnt_wdata = 16'(n);
    @(negedge clk);
    brk_cnt_wr = 1'b0; brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
    if (n == 0) begin
      chk("R7 zero count done pulse", int'(brk_done), 1);
      chk("R7 zero count never active", int'(brk_active), 0);
      @(negedge clk);
      chk("R7 done is one cycle", int'(brk_done), 0);
      chk("R7 still inactive", int'(brk_active), 0);
      return;
    end
    chk("R6 active after start", int'(brk_active), 1);
    while (!seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      brk_start = 1'b0;
      brk_cnt_wr = 1'b0;
      if (bit_tick) ticks++;
      if (brk_done) begin
        seen = 1'b1;
        chk("R6 break length in bit strobes", ticks, n);
        chk("R6 done with bit strobe", int'(bit_tick), 1);
        chk("R6 inactive at done", int'(brk_active), 0);
      end else if (retrig && !trig && ticks == 1) begin
        trig = 1'b1;
        brk_start = 1'b1;
        brk_cnt_wr = 1'b1;
        brk_cnt_wdata = 16'(n + 7);
      end
    end
    brk_start = 1'b0;
    brk_cnt_wr = 1'b0;
    chk("R6 done seen", int'(seen), 1);
    @(negedge clk);
    chk("R6 done is one cycle", int'(brk_done), 0);
    if (retrig) chk("R8 no restart after ignored request", int'(brk_active), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p, d, k, nb;
    logic [31:0] w1, w2;
    void'($urandom(32'h1C3A_5B7D));
    repeat (3) @(negedge clk);
    chk("R9 reset sample_tick", int'(sample_tick), 0);
    chk("R9 reset bit_tick", int'(bit_tick), 0);
    chk("R9 reset busy", int'(div_busy), 0);
    chk("R9 reset brk_active", int'(brk_active), 0);
    chk("R9 reset brk_done", int'(brk_done), 0);
    rst_n = 1'b1;
    measure(0, 0, 1'b1, "R9 default zero divisor R2");

    // R1: junk outside the two fields
    set_div(make_word(2, 3, 32'hFFFF_FFFF), 1'b1, 0);
    measure(2, 3, 1'b1, "R1 R2");

    // R10: second write while pending replaces the first
    tx_idle = 1'b0;
    @(negedge clk);
    w1 = make_word(5, 1, 32'h0);
    w2 = make_word(1, 4, 32'hA5A5_0000);
    div_wr = 1'b1; div_wdata = w1;
    @(negedge clk);
    div_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 busy before rewrite", int'(div_busy), 1);
    set_div(w2, 1'b0, 6);
    measure(1, 4, 1'b1, "R10 R2");

    // Largest field values: first sample strobe only
    set_div(make_word(15, 1023, 32'h0), 1'b1, 0);
    measure(15, 1023, 1'b0, "R1 R2 max fields");

    // Random rates, mixed apply conditions
    for (int it = 0; it < 6; it++) begin
      p = int'($urandom % 4);
      d = int'($urandom % 6);
      k = 1 + int'($urandom % 5);
      set_div(make_word(p, d, $urandom), ($urandom % 2) == 0, k);
      measure(p, d, 1'b1, "R2 random");
    end

    // Breaks
    set_div(make_word(0, 0, 32'h0), 1'b1, 0);
    run_break(3, 1'b1);
    run_break(0, 1'b0);
    run_break(1, 1'b0);
    for (int it = 0; it < 4; it++) begin
      p = int'($urandom % 3);
      d = int'($urandom % 3);
      nb = int'($urandom % 5);
      set_div(make_word(p, d, 32'h0), 1'b1, 0);
      run_break(nb, nb >= 2);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule